// File: doc/BRIEF.md
# Latched-Address One-of-Eight Decoder

This block turns a three-bit address into a selection on one of eight output lines. The address first passes through a hold stage. While the hold control is low the stage is transparent and follows the live address. While it is high the stage keeps the last address it saw. Two enables of opposite sense gate the whole output. Line selection happens only when the active-high enable is 1 and the active-low enable is 0. In every other case all eight lines rest at their inactive level.

A compile-time parameter sets the output sense, so that the chosen line is either driven low among high lines or driven high among low lines. The block also works as a one-to-eight demultiplexer. One enable is tied to its active level and a data stream is fed into the other enable. The addressed line then carries that stream.

The outputs are registered, with a synchronous active-high reset. The hold stage is a level-sensitive latch by default. A parameter replaces it with a clocked register for flows that use flip-flops only.

Top module: `addr_latch_dec`

## Requirements
- R1: While reset is high, every output line is at its inactive level and the held address is cleared to 0. If the hold control stays high after reset and both enables are active, line 0 is selected.
- R2: With the hold control low and both enables active, the output selects the line given by the live address, one rising clock edge after the inputs are applied (latch variant).
- R3: With the hold control high, the output decodes the last address present while the hold control was low. Address changes during that time have no effect on the outputs.
- R4: When the active-low enable `en_lo_n` is 1, all eight lines are inactive, whatever the address or hold control.
- R5: When the active-high enable `en_hi` is 0, all eight lines are inactive, whatever the address or hold control.
- R6: With `ACTIVE_HIGH` = 0, the selected line is 0 and all the others are 1. With `ACTIVE_HIGH` = 1, the selected line is 1 and all the others are 0. The enable gating is the same in both cases.
- R7: Address bit 0 is the least significant bit. Address value N selects output bit N of `line_o`, for N from 0 to 7.
- R8: At most one output line is at its active level at any time.
- R9: Demultiplexing is supported in both directions. With `en_lo_n` held at 0, the addressed line is active exactly in the cycles where the data on `en_hi` is 1. With `en_hi` held at 1, the addressed line is active exactly where the data on `en_lo_n` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register (and the hold register in the flop variant) |
| rst | input | 1 | Synchronous reset, active high |
| addr_i | input | ADDR_W | Line address, bit 0 least significant |
| hold_i | input | 1 | Hold control: 0 transparent, 1 keep address |
| en_hi | input | 1 | Enable, active high |
| en_lo_n | input | 1 | Enable, active low |
| line_o | output | 2**ADDR_W | Decoded output lines, sense set by ACTIVE_HIGH |

## Verification
In the latch variant, every result is due one rising edge after its inputs settle. This covers a new address, a change of enable, and a demultiplexed data bit, because the only register on the way is the output register. The bench drives inputs on the falling edge and samples one time unit after the next rising edge. Its reference model updates the bench-side held address at the moment of driving, using the value of the hold control. Hold checks first move the address while the hold control is high, then compare at that same sample point. Any leak through the hold stage would therefore show up in the very cycle it happens.

// File: rtl/ald_pkg.sv
package ald_pkg;

  typedef enum logic {
    SENSE_LOW  = 1'b0,
    SENSE_HIGH = 1'b1
  } sense_e;

  // Both enables must sit at their active level for any line to be driven
  function automatic logic gate_open(input logic hi_en, input logic lo_en_n);
    return hi_en & ~lo_en_n;
  endfunction

endpackage

// File: rtl/ald_addr_hold.sv
module ald_addr_hold #(
  parameter int ADDR_W   = 3,
  parameter bit USE_FLOP = 1'b0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              hold,
  input  logic [ADDR_W-1:0] addr,
  output logic [ADDR_W-1:0] held
);

  generate
    if (USE_FLOP) begin : g_flop
      always_ff @(posedge clk) begin
        if (rst)        held <= '0;
        else if (!hold) held <= addr;
      end
    end else begin : g_latch
      always_latch begin
        if (rst)        held = '0;
        else if (!hold) held = addr;
      end
    end
  endgenerate

  // R3
  hold_stable_chk: assert property (@(posedge clk) disable iff (rst)
    (hold && $past(hold) && !$past(rst)) |-> $stable(held));

endmodule

// File: rtl/ald_line_decode.sv
module ald_line_decode #(
  parameter int ADDR_W      = 3,
  parameter bit ACTIVE_HIGH = 1'b0,
  localparam int LINES      = 1 << ADDR_W
) (
  input  logic              open,
  input  logic [ADDR_W-1:0] sel,
  output logic [LINES-1:0]  lines
);

  logic [LINES-1:0] hit;

  genvar i;
  generate
    for (i = 0; i < LINES; i++) begin : g_line
      assign hit[i] = open && (sel == ADDR_W'(i));
    end
    if (ACTIVE_HIGH) begin : g_pos
      assign lines = hit;
    end else begin : g_neg
      assign lines = ~hit;
    end
  endgenerate

endmodule

// File: rtl/addr_latch_dec.sv
module addr_latch_dec #(
  parameter int ADDR_W      = 3,
  parameter bit ACTIVE_HIGH = 1'b0,
  parameter bit USE_FLOP    = 1'b0,
  localparam int LINES      = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              hold_i,
  input  logic              en_hi,
  input  logic              en_lo_n,
  output logic [LINES-1:0]  line_o
);
  import ald_pkg::*;

  localparam sense_e        SENSE = ACTIVE_HIGH ? SENSE_HIGH : SENSE_LOW;
  localparam logic          IDLE  = (SENSE == SENSE_HIGH) ? 1'b0 : 1'b1;
  localparam logic [LINES-1:0] IDLE_VEC = {LINES{IDLE}};

  logic [ADDR_W-1:0] held_addr;
  logic [LINES-1:0]  lines_next;
  logic              open;

  assign open = gate_open(en_hi, en_lo_n);

  ald_addr_hold #(
    .ADDR_W  (ADDR_W),
    .USE_FLOP(USE_FLOP)
  ) u_hold (
    .clk (clk),
    .rst (rst),
    .hold(hold_i),
    .addr(addr_i),
    .held(held_addr)
  );

  ald_line_decode #(
    .ADDR_W     (ADDR_W),
    .ACTIVE_HIGH(ACTIVE_HIGH)
  ) u_dec (
    .open (open),
    .sel  (held_addr),
    .lines(lines_next)
  );

  always_ff @(posedge clk) begin
    if (rst) line_o <= IDLE_VEC;
    else     line_o <= lines_next;
  end

  // R4
  lo_enable_off_chk: assert property (@(posedge clk) disable iff (rst)
    en_lo_n |=> (line_o == IDLE_VEC));

  // R5
  hi_enable_off_chk: assert property (@(posedge clk) disable iff (rst)
    !en_hi |=> (line_o == IDLE_VEC));

  // R8
  single_active_chk: assert property (@(posedge clk) disable iff (rst)
    (ACTIVE_HIGH ? $onehot0(line_o) : $onehot0(~line_o)));

  // R7
  addressed_line_chk: assert property (@(posedge clk) disable iff (rst)
    (en_hi && !en_lo_n) |=> (line_o[$past(held_addr)] == ~IDLE));

endmodule

// File: tb/addr_latch_dec_test.sv
module addr_latch_dec_test;

  localparam int AW = 3;
  localparam int NL = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] addr;
  logic          hold;
  logic          eh;
  logic          eln;
  logic [NL-1:0] lo_out;
  logic [NL-1:0] hi_out;

  int checks = 0;
  int fails  = 0;
  logic [AW-1:0] held_m;
  bit done = 1'b0;

  always #4 clk = ~clk;

  addr_latch_dec #(.ADDR_W(AW), .ACTIVE_HIGH(1'b0)) uut (
    .clk(clk), .rst(rst), .addr_i(addr), .hold_i(hold),
    .en_hi(eh), .en_lo_n(eln), .line_o(lo_out));

  addr_latch_dec #(.ADDR_W(AW), .ACTIVE_HIGH(1'b1)) uut_hi (
    .clk(clk), .rst(rst), .addr_i(addr), .hold_i(hold),
    .en_hi(eh), .en_lo_n(eln), .line_o(hi_out));

  function automatic logic [NL-1:0] expect_lines(input logic [AW-1:0] a,
      input logic h, input logic ln, input logic pol);
    logic [NL-1:0] v;
    v = '0;
    if (h && !ln) v[a] = 1'b1;
    return pol ? v : ~v;
  endfunction

  task automatic check(input string req, input logic [NL-1:0] act,
                       input logic [NL-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(input string req, input logic h, input logic [AW-1:0] a,
                      input logic e_hi, input logic e_lo_n);
    @(negedge clk);
    hold = h; addr = a; eh = e_hi; eln = e_lo_n;
    if (!h) held_m = a;
    @(posedge clk);
    #1;
    check({req, " low-sense"},  lo_out, expect_lines(held_m, eh, eln, 1'b0));
    check({req, " high-sense"}, hi_out, expect_lines(held_m, eh, eln, 1'b1));
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst = 1'b1; hold = 1'b1; addr = 3'd5; eh = 1'b1; eln = 1'b0;
    held_m = '0;
    repeat (3) @(posedge clk);
    #1;
    // R1: reset forces the inactive level
    check("R1 reset low-sense",  lo_out, {NL{1'b1}});
    check("R1 reset high-sense", hi_out, {NL{1'b0}});
    @(negedge clk); rst = 1'b0;
    @(posedge clk); #1;
    // R1: held address cleared, so line 0 is chosen while holding
    check("R1 post-reset line0", hi_out, 8'b0000_0001);
    step("R1 hold after reset", 1'b1, 3'd6, 1'b1, 1'b0);

    // R2 R4 R5 R6 R7: all enable pairs and addresses, transparent
    for (int e = 0; e < 4; e++) begin
      for (int a = 0; a < NL; a++) begin
        step(e == 2 ? "R2 R7 decode" : (e[1] ? "R4 lo-enable off"
             : "R5 hi-enable off"),
             1'b0, AW'(a), e[1], e[0]);
      end
    end

    // R3: load an address, then move it while holding
    step("R3 load", 1'b0, 3'd3, 1'b1, 1'b0);
    for (int k = 0; k < NL; k++) begin
      step("R3 held ignores addr", 1'b1, AW'(k), 1'b1, 1'b0);
    end
    step("R3 release", 1'b0, 3'd7, 1'b1, 1'b0);

    // R9: data on active-high enable, low enable held active
    for (int k = 0; k < 16; k++) begin
      step("R9 demux on en_hi", 1'b0, 3'd2, 1'($urandom_range(0, 1)), 1'b0);
    end
    // R9: data on active-low enable, high enable held active
    for (int k = 0; k < 16; k++) begin
      step("R9 demux on en_lo_n", 1'b1, 3'd0, 1'b1, 1'($urandom_range(0, 1)));
    end

    // R8 and mixed behaviour under random stimulus
    for (int k = 0; k < 300; k++) begin
      step("R8 R3 random", 1'($urandom_range(0, 1)), AW'($urandom_range(0, NL - 1)),
           1'($urandom_range(0, 3) != 0), 1'($urandom_range(0, 3) == 0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule